// File: doc/BRIEF.md
# Maskable BCD Alarm Comparator

This block watches a running calendar and fires when it reaches the time held in a 32-bit alarm word. Seconds, minutes and hours are compared as BCD values, and each of them can be taken out of the comparison with its own ignore bit. The day part of the word holds either a day of the month or a weekday. A separate bit removes the day from the comparison, so the alarm then fires every day. Month and year are never compared.

The calendar block pulses `tick` once per second, in the cycle where the calendar inputs show the new second. On that pulse, if the alarm is enabled and the word matches, the block sets a sticky alarm flag. The flag stays set until it is cleared. The interrupt output is high while both the flag and the interrupt enable are high.

Software may rewrite the alarm word only through a handshake. It first clears the alarm enable, then waits for the write-allowed status to rise a fixed number of cycles later, and then writes the word.

Top module: `alarm_cmp`

## Requirements
- R1: The seconds field is word bits 6:0, compared with `cal_sec`. When bit 7 of the word is 1, the seconds do not affect the match.
- R2: The minutes field is word bits 14:8, compared with `cal_min`. When bit 15 of the word is 1, the minutes do not affect the match.
- R3: Word bits 21:16 are compared with `cal_hour`, and word bit 22 is compared with `cal_pm`. When bit 23 of the word is 1, neither the hour nor the PM bit affects the match.
- R4: When word bit 30 is 0, bits 29:24 are compared with `cal_date`. When bit 30 is 1, bits 27:24 are compared with `{1'b0, cal_wday}`, where 1 means Monday and 7 means Sunday. When word bit 31 is 1, the day does not affect the match.
- R5: The flag is set at the clock edge where `tick` is high, `alm_en_q` is high and the word matches. There is no other way for it to be set.
- R6: The flag stays at 1 until the edge where `flag_clr` is high. If a set and a clear meet at the same edge, the set wins.
- R7: `irq` is high exactly when `flag_q` and `irq_en_q` are both high.
- R8: `wr_ok` is 0 from the edge where the enable is written to 1. It rises SYNC_CYC edges after the edge where the enable is written to 0 (2 edges by default).
- R9: A write pulse on `word_we` loads `word_wdata` only when `wr_ok` is 1. Otherwise the write is ignored.
- R10: After reset the word is 0, both enables are 0, the flag is 0 and `wr_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per calendar second |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 6 | Current hours, BCD |
| cal_pm | input | 1 | Current PM indicator |
| cal_date | input | 6 | Current day of month, BCD |
| cal_wday | input | 3 | Current weekday, 1 to 7 |
| ctl_we | input | 1 | Write strobe for both enables |
| ctl_alm_en | input | 1 | Alarm enable value to write |
| ctl_irq_en | input | 1 | Interrupt enable value to write |
| flag_clr | input | 1 | Clears the alarm flag |
| word_we | input | 1 | Alarm word write strobe |
| word_wdata | input | WORD_W | Alarm word write data |
| word_q | output | WORD_W | Current alarm word |
| alm_en_q | output | 1 | Alarm enable |
| irq_en_q | output | 1 | Interrupt enable |
| flag_q | output | 1 | Sticky alarm flag |
| wr_ok | output | 1 | Alarm word may be written |
| irq | output | 1 | Alarm interrupt |

## Verification
Two events can land on the same edge: a tick that matches the word, and a software clear of the flag. The bench drives `tick` with matching calendar values and `flag_clr` in the same cycle, and expects the flag to stay at 1.

A second collision is a write to the word in the cycle the enable is written to 1, while `wr_ok` is still high. That write must take effect.

A per-cycle behavioural model predicts every output, and each prediction is compared against the design one clock edge later.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
   // Width of one BCD time field slot in the alarm word.
   localparam int FLD_W      = 7;
   // Number of time fields: seconds, minutes, hours.
   localparam int TIME_FLDS  = 3;
   localparam int SLOT_W     = 8;
   localparam int DAY_LO     = 24;
   localparam int DATE_W     = 6;
   localparam int WDAY_W     = 4;
   localparam int DAY_SEL    = 30;
   localparam int DAY_IGN    = 31;

   function automatic int slot_lo(input int idx);
      return idx * SLOT_W;
   endfunction

   function automatic int slot_ign(input int idx);
      return idx * SLOT_W + FLD_W;
   endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
   parameter int W = 7
) (
   input  logic [W-1:0] want,
   input  logic [W-1:0] have,
   input  logic         ignore,
   output logic         hit
);
   assign hit = ignore | (want == have);
endmodule

// File: rtl/alarm_match.sv
module alarm_match
   import alarm_cmp_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word,
   input  logic [6:0]        cal_sec,
   input  logic [6:0]        cal_min,
   input  logic [5:0]        cal_hour,
   input  logic              cal_pm,
   input  logic [5:0]        cal_date,
   input  logic [2:0]        cal_wday,
   output logic              hit
);
   logic [TIME_FLDS-1:0][FLD_W-1:0] have_t;
   logic [TIME_FLDS-1:0]            t_hit;
   logic                            date_hit;
   logic                            wday_hit;
   logic                            day_hit;

   assign have_t = {{cal_pm, cal_hour}, cal_min, cal_sec};

   for (genvar g = 0; g < TIME_FLDS; g++) begin : g_time
      alarm_field_cmp #(.W(FLD_W)) u_fld (
         .want   (word[slot_lo(g) +: FLD_W]),
         .have   (have_t[g]),
         .ignore (word[slot_ign(g)]),
         .hit    (t_hit[g])
      );
   end

   alarm_field_cmp #(.W(DATE_W)) u_date (
      .want   (word[DAY_LO +: DATE_W]),
      .have   (cal_date),
      .ignore (1'b0),
      .hit    (date_hit)
   );

   alarm_field_cmp #(.W(WDAY_W)) u_wday (
      .want   (word[DAY_LO +: WDAY_W]),
      .have   ({1'b0, cal_wday}),
      .ignore (1'b0),
      .hit    (wday_hit)
   );

   assign day_hit = word[DAY_IGN] | (word[DAY_SEL] ? wday_hit : date_hit);
   assign hit     = (&t_hit) & day_hit;
endmodule

// File: rtl/alarm_wr_gate.sv
module alarm_wr_gate #(
   parameter int SYNC_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_q,
   input  logic en_nx,
   output logic wr_ok
);
   localparam int CNT_W = $clog2(SYNC_CYC + 1);

   logic [CNT_W-1:0] cnt;

   // Counting starts on the first edge at which the enable is already low.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         wr_ok <= 1'b1;
      end else if (en_nx) begin
         cnt   <= '0;
         wr_ok <= 1'b0;
      end else if (!en_q && !wr_ok) begin
         if (cnt == CNT_W'(SYNC_CYC - 1)) begin
            wr_ok <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
   parameter int SYNC_CYC = 2,
   parameter int WORD_W   = 32,
   parameter int IRQ_REG  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [6:0]        cal_sec,
   input  logic [6:0]        cal_min,
   input  logic [5:0]        cal_hour,
   input  logic              cal_pm,
   input  logic [5:0]        cal_date,
   input  logic [2:0]        cal_wday,
   input  logic              ctl_we,
   input  logic              ctl_alm_en,
   input  logic              ctl_irq_en,
   input  logic              flag_clr,
   input  logic              word_we,
   input  logic [WORD_W-1:0] word_wdata,
   output logic [WORD_W-1:0] word_q,
   output logic              alm_en_q,
   output logic              irq_en_q,
   output logic              flag_q,
   output logic              wr_ok,
   output logic              irq
);
   if (WORD_W != 32) begin : g_bad_width
      $error("alarm_cmp: WORD_W must be 32");
   end
   if (SYNC_CYC < 1) begin : g_bad_sync
      $error("alarm_cmp: SYNC_CYC must be at least 1");
   end
   if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
      $error("alarm_cmp: IRQ_REG must be 0 or 1");
   end

   logic hit;
   logic en_nx;

   assign en_nx = ctl_we ? ctl_alm_en : alm_en_q;

   alarm_match #(.WORD_W(WORD_W)) u_match (
      .word     (word_q),
      .cal_sec  (cal_sec),
      .cal_min  (cal_min),
      .cal_hour (cal_hour),
      .cal_pm   (cal_pm),
      .cal_date (cal_date),
      .cal_wday (cal_wday),
      .hit      (hit)
   );

   alarm_wr_gate #(.SYNC_CYC(SYNC_CYC)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .en_q  (alm_en_q),
      .en_nx (en_nx),
      .wr_ok (wr_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         alm_en_q <= 1'b0;
         irq_en_q <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         if (ctl_we) begin
            alm_en_q <= ctl_alm_en;
            irq_en_q <= ctl_irq_en;
         end
         if (word_we && wr_ok) begin
            word_q <= word_wdata;
         end
         // Set beats clear.
         if (tick && alm_en_q && hit) begin
            flag_q <= 1'b1;
         end else if (flag_clr) begin
            flag_q <= 1'b0;
         end
      end
   end

   if (IRQ_REG == 1) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= flag_q & irq_en_q;
      end
   end else begin : g_irq_comb
      assign irq = flag_q & irq_en_q;
   end
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk #(
   parameter int WORD_W  = 32,
   parameter int IRQ_REG = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              flag_clr,
   input logic              word_we,
   input logic [WORD_W-1:0] word_q,
   input logic              alm_en_q,
   input logic              irq_en_q,
   input logic              flag_q,
   input logic              wr_ok,
   input logic              irq
);
   a_r5_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tick && alm_en_q));

   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q);

   a_r8_busy_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      alm_en_q |-> !wr_ok);

   a_r8_rise_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_ok) |-> $past(!alm_en_q));

   a_r9_word_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(word_q) |-> $past(word_we && wr_ok));

   if (IRQ_REG == 1) begin : g_irq_r
      a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(flag_q && irq_en_q));
   end else begin : g_irq_c
      a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (flag_q && irq_en_q));
   end
endmodule

bind alarm_cmp alarm_cmp_chk #(.WORD_W(WORD_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .flag_clr (flag_clr),
   .word_we  (word_we),
   .word_q   (word_q),
   .alm_en_q (alm_en_q),
   .irq_en_q (irq_en_q),
   .flag_q   (flag_q),
   .wr_ok    (wr_ok),
   .irq      (irq)
);

// File: tb/alarm_cmp_tb.sv
`timescale 1ns/1ps
module alarm_cmp_tb;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [6:0]  cal_sec = '0;
   logic [6:0]  cal_min = '0;
   logic [5:0]  cal_hour = '0;
   logic        cal_pm = 1'b0;
   logic [5:0]  cal_date = '0;
   logic [2:0]  cal_wday = '0;
   logic        ctl_we = 1'b0;
   logic        ctl_alm_en = 1'b0;
   logic        ctl_irq_en = 1'b0;
   logic        flag_clr = 1'b0;
   logic        word_we = 1'b0;
   logic [31:0] word_wdata = '0;
   logic [31:0] word_q;
   logic        alm_en_q, irq_en_q, flag_q, wr_ok, irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   alarm_cmp #(.SYNC_CYC(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour), .cal_pm(cal_pm),
      .cal_date(cal_date), .cal_wday(cal_wday),
      .ctl_we(ctl_we), .ctl_alm_en(ctl_alm_en), .ctl_irq_en(ctl_irq_en),
      .flag_clr(flag_clr), .word_we(word_we), .word_wdata(word_wdata),
      .word_q(word_q), .alm_en_q(alm_en_q), .irq_en_q(irq_en_q),
      .flag_q(flag_q), .wr_ok(wr_ok), .irq(irq)
   );

   // Behavioural reference model
   logic [31:0] m_word;
   bit m_en, m_ie, m_flag, m_ok;
   int m_low;

   function automatic bit ref_match(input logic [31:0] w);
      int want_s, want_m, want_h, want_d;
      bit use_wday;
      want_s = w[7]  ? -1 : int'(w[6:0]);
      want_m = w[15] ? -1 : int'(w[14:8]);
      want_h = w[23] ? -1 : int'(w[22:16]);
      use_wday = w[30];
      want_d = w[31] ? -1 : (use_wday ? int'(w[27:24]) : int'(w[29:24]));
      if (want_s >= 0 && want_s != int'(cal_sec)) return 0;
      if (want_m >= 0 && want_m != int'(cal_min)) return 0;
      if (want_h >= 0 && want_h != int'({cal_pm, cal_hour})) return 0;
      if (want_d >= 0 && use_wday && want_d != int'(cal_wday)) return 0;
      if (want_d >= 0 && !use_wday && want_d != int'(cal_date)) return 0;
      return 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_word = '0; m_en = 0; m_ie = 0; m_flag = 0; m_ok = 1; m_low = SYNC;
      end else begin
         bit en_nx, fl_nx, ok_nx;
         logic [31:0] w_nx;
         en_nx = ctl_we ? ctl_alm_en : m_en;
         w_nx  = (word_we && m_ok) ? word_wdata : m_word;
         fl_nx = m_flag;
         if (tick && m_en && ref_match(m_word)) fl_nx = 1;
         else if (flag_clr) fl_nx = 0;
         ok_nx = m_ok;
         if (en_nx) begin
            m_low = 0; ok_nx = 0;
         end else if (!m_en) begin
            m_low++;
            if (m_low >= SYNC) ok_nx = 1;
         end
         if (ctl_we) m_ie = ctl_irq_en;
         m_en = en_nx; m_word = w_nx; m_flag = fl_nx; m_ok = ok_nx;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9", "word_q", word_q, m_word);
         chk("R10", "alm_en_q", 32'(alm_en_q), 32'(m_en));
         chk("R10", "irq_en_q", 32'(irq_en_q), 32'(m_ie));
         chk("R5/R6", "flag_q", 32'(flag_q), 32'(m_flag));
         chk("R8", "wr_ok", 32'(wr_ok), 32'(m_ok));
         chk("R7", "irq", 32'(irq), 32'(m_flag && m_ie));
      end
   end

   task automatic cyc();
      @(negedge clk);
      tick = 0; ctl_we = 0; flag_clr = 0; word_we = 0;
   endtask

   task automatic tk(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                     input logic pm, input logic [5:0] d, input logic [2:0] wd, input bit clr);
      cal_sec = s; cal_min = m; cal_hour = h; cal_pm = pm; cal_date = d; cal_wday = wd;
      tick = 1; flag_clr = clr;
      cyc();
   endtask

   task automatic set_ctl(input bit en, input bit ie);
      ctl_we = 1; ctl_alm_en = en; ctl_irq_en = ie;
      cyc();
   endtask

   task automatic wr_word(input logic [31:0] w);
      word_we = 1; word_wdata = w;
      cyc();
   endtask

   task automatic clr_flag();
      flag_clr = 1;
      cyc();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: reset state
      chk("R10", "reset word", word_q, 32'h0);
      chk("R10", "reset flag", 32'(flag_q), 32'h0);
      chk("R10", "reset wr_ok", 32'(wr_ok), 32'h1);

      // 08:15:30, day ignored
      wr_word(32'h8008_1530);
      chk("R9", "write accepted", word_q, 32'h8008_1530);
      set_ctl(1, 1);
      chk("R8", "wr_ok low when enabled", 32'(wr_ok), 32'h0);
      tk(7'h29, 7'h15, 6'h08, 0, 6'h01, 3'd1, 0);
      chk("R1", "seconds mismatch", 32'(flag_q), 32'h0);
      tk(7'h30, 7'h15, 6'h08, 0, 6'h22, 3'd5, 0);
      chk("R5", "match sets flag (R4 day ignored)", 32'(flag_q), 32'h1);
      chk("R7", "irq raised", 32'(irq), 32'h1);
      cyc();
      chk("R6", "flag held", 32'(flag_q), 32'h1);
      clr_flag();
      chk("R6", "flag cleared", 32'(flag_q), 32'h0);
      tk(7'h30, 7'h16, 6'h08, 0, 6'h01, 3'd1, 0);
      chk("R2", "minutes mismatch", 32'(flag_q), 32'h0);
      tk(7'h30, 7'h15, 6'h09, 0, 6'h01, 3'd1, 0);
      chk("R3", "hours mismatch", 32'(flag_q), 32'h0);
      tk(7'h30, 7'h15, 6'h08, 1, 6'h01, 3'd1, 0);
      chk("R3", "pm mismatch", 32'(flag_q), 32'h0);
      // match together with clear: set wins
      tk(7'h30, 7'h15, 6'h08, 0, 6'h01, 3'd1, 1);
      chk("R6", "set wins over clear", 32'(flag_q), 32'h1);
      clr_flag();
      set_ctl(1, 0);
      tk(7'h30, 7'h15, 6'h08, 0, 6'h01, 3'd1, 0);
      chk("R7", "irq masked", 32'(irq), 32'h0);
      chk("R5", "flag without irq enable", 32'(flag_q), 32'h1);
      wr_word(32'h1712_4580);
      chk("R9", "write ignored while busy", word_q, 32'h8008_1530);
      clr_flag();
      // disable and time the handshake
      set_ctl(0, 1);
      chk("R8", "wr_ok edge 0", 32'(wr_ok), 32'h0);
      tk(7'h30, 7'h15, 6'h08, 0, 6'h01, 3'd1, 0);
      chk("R5", "no flag while disabled", 32'(flag_q), 32'h0);
      chk("R8", "wr_ok edge 1", 32'(wr_ok), 32'h0);
      cyc();
      chk("R8", "wr_ok edge 2", 32'(wr_ok), 32'h1);

      // seconds ignored, 12:45, date 17
      wr_word(32'h1712_4580);
      set_ctl(1, 1);
      tk(7'h07, 7'h45, 6'h12, 0, 6'h17, 3'd2, 0);
      chk("R1", "seconds ignored, R4 date match", 32'(flag_q), 32'h1);
      clr_flag();
      tk(7'h07, 7'h45, 6'h12, 0, 6'h18, 3'd2, 0);
      chk("R4", "date mismatch", 32'(flag_q), 32'h0);

      // weekday 3, minutes ignored, 23:xx:10
      set_ctl(0, 1);
      repeat (SYNC) cyc();
      wr_word(32'h4323_8010);
      // enable write and word write in the same cycle (wr_ok still high)
      ctl_we = 1; ctl_alm_en = 1; ctl_irq_en = 1; word_we = 1; word_wdata = 32'h4323_8010;
      cyc();
      chk("R9", "write with enable same edge", word_q, 32'h4323_8010);
      tk(7'h10, 7'h59, 6'h23, 0, 6'h05, 3'd3, 0);
      chk("R2", "minutes ignored, R4 weekday match", 32'(flag_q), 32'h1);
      clr_flag();
      tk(7'h10, 7'h59, 6'h23, 0, 6'h03, 3'd4, 0);
      chk("R4", "weekday mismatch", 32'(flag_q), 32'h0);
      repeat (4) cyc();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule